// File: doc/BRIEF.md
# Invert-and-Select ALU

This block is a purely combinational arithmetic and logic unit of configurable width, 32 bits by default. It takes two operands and a 4-bit control word and produces a result, a zero flag and a signed overflow flag. The control word has three fields. Bit 3 inverts operand A and bit 2 inverts operand B. Bits 1:0 select one of four output paths: bitwise AND (00), bitwise OR (01), the adder (10) and the less-than path (11).

Subtraction, NOR and signed set-on-less-than have no hardware of their own. They are built from one shared AND/OR/adder core. The core inverts operands where the control word asks, forces a carry-in of 1 whenever B is inverted, and sends the signed comparison outcome to bit 0 of the result. The block sits in a single-cycle datapath and is driven by a small decoder that turns instruction fields into one of six supported control codes.

Top module: `inv_sel_alu`

## Requirements
- R1: Control code 4'b0000 gives the result A AND B.
- R2: Control code 4'b0001 gives the result A OR B.
- R3: Control code 4'b0010 gives the result A + B, taken modulo 2^W.
- R4: Control code 4'b0110 gives the result A - B, taken modulo 2^W.
- R5: Control code 4'b0111 drives result bits W-1:1 to zero. Result bit 0 is 1 exactly when A < B with both operands read as two's-complement signed numbers. This holds even when A - B overflows.
- R6: Control code 4'b1100 gives the result NOT (A OR B).
- R7: The zero flag is 1 exactly when every bit of the result is 0.
- R8: For codes 4'b0010 and 4'b0110, the overflow flag is 1 exactly when the signed result falls outside the W-bit two's-complement range.
- R9: For every control code other than 4'b0010 and 4'b0110, the overflow flag is 0.
- R10: Every control code not listed in R1 to R6 gives an all-zero result, with the zero flag at 1 and the overflow flag at 0.
- R11: R1 to R10 hold at the width parameter W = 4 as well as at W = 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| ctl_i | input | 4 | Control word: bit 3 inverts A, bit 2 inverts B, bits 1:0 select the output path |
| res_o | output | W | Result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow, valid for add and subtract only |

## Verification
The bench goes after the signed extremes, where the operands are the most negative and most positive values, along with 0 and -1. These inputs expose two common bugs. A less-than taken from the raw difference sign would return the wrong answer once the subtraction overflows. An overflow test taken from the raw operands instead of the inverted B would misflag subtraction.

A missing carry-in on the inverted path would leave subtract and set-on-less-than off by one. Codes outside the six listed ones leak the output of whichever path bits 1:0 happen to select, unless they are forced to zero. The bench covers this by sweeping all sixteen control codes.

At W = 4 every operand pair is tried under every code. Any width-dependent sign-bit or range bug therefore shows up there. At W = 32 the bench uses seeded random operands.

// File: rtl/inv_sel_alu.sv
module inv_sel_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   ctl_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         ovf_o
);
  logic         inv_a, inv_b;
  logic [1:0]   fn;
  logic [W-1:0] opa, opb, sum, pick;
  logic         sgn_ovf, lt, known, arith;

  assign {inv_a, inv_b, fn} = ctl_i;

  assign opa = inv_a ? ~a_i : a_i;
  assign opb = inv_b ? ~b_i : b_i;
  assign sum = opa + opb + {{(W-1){1'b0}}, inv_b};

  assign sgn_ovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
  assign lt      = sum[W-1] ^ sgn_ovf;

  always_comb begin
    case (ctl_i)
      4'b0000, 4'b0001, 4'b0010,
      4'b0110, 4'b0111, 4'b1100: known = 1'b1;
      default:                   known = 1'b0;
    endcase
  end

  always_comb begin
    case (fn)
      2'd0:    pick = opa & opb;
      2'd1:    pick = opa | opb;
      2'd2:    pick = sum;
      default: pick = {{(W-1){1'b0}}, lt};
    endcase
  end

  assign arith  = (ctl_i == 4'b0010) || (ctl_i == 4'b0110);
  assign res_o  = known ? pick : '0;
  assign zero_o = ~|res_o;
  assign ovf_o  = arith & sgn_ovf;
endmodule

// File: rtl/inv_sel_alu_chk.sv
module inv_sel_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [3:0]   ctl_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         ovf_o
);
  logic [W-1:0] nor_v, dif_v, add_v;
  assign nor_v = ~(a_i | b_i);
  assign dif_v = a_i - b_i;
  assign add_v = a_i + b_i;

  always_comb begin
    AST_AND_PATH: assert (ctl_i != 4'b0000 || res_o == (a_i & b_i)); // R1
    AST_ADD_PATH: assert (ctl_i != 4'b0010 || res_o == add_v); // R3
    AST_SUB_PATH: assert (ctl_i != 4'b0110 || res_o == dif_v); // R4
    AST_SLT_UPPER: assert (ctl_i != 4'b0111 || (res_o >> 1) == '0); // R5
    AST_NOR_PATH: assert (ctl_i != 4'b1100 || res_o == nor_v); // R6
    AST_NO_OVERFLOW: assert (ctl_i == 4'b0010 || ctl_i == 4'b0110 || !ovf_o); // R9
    AST_UNLISTED_CLEAR: assert (ctl_i == 4'b0000 || ctl_i == 4'b0001 || ctl_i == 4'b0010 || ctl_i == 4'b0110 || ctl_i == 4'b0111 || ctl_i == 4'b1100 || (res_o == '0 && zero_o)); // R10
  end
endmodule

bind inv_sel_alu inv_sel_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_inv_sel_alu.sv
module sim_inv_sel_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] a32, b32, r32;
  logic [3:0]  c32, a4, b4, c4, r4;
  logic        z32, v32, z4, v4;

  inv_sel_alu #(.W(32)) u0 (.a_i(a32), .b_i(b32), .ctl_i(c32), .res_o(r32), .zero_o(z32), .ovf_o(v32));
  // R11: the same design at width 4
  inv_sel_alu #(.W(4))  u1 (.a_i(a4),  .b_i(b4),  .ctl_i(c4),  .res_o(r4),  .zero_o(z4),  .ovf_o(v4));

  function automatic string req_of(logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic longint sext(longint u, int w);
    longint half = longint'(1) << (w - 1);
    return (u >= half) ? u - (longint'(1) << w) : u;
  endfunction

  function automatic void ref_alu(input int w, input logic [31:0] a, input logic [31:0] b,
                                  input logic [3:0] c, output logic [31:0] r, output logic v);
    longint m   = (longint'(1) << w) - 1;
    longint ua  = longint'({32'd0, a}) & m;
    longint ub  = longint'({32'd0, b}) & m;
    longint sa  = sext(ua, w);
    longint sb  = sext(ub, w);
    longint mx  = (longint'(1) << (w - 1)) - 1;
    longint mn  = -(longint'(1) << (w - 1));
    longint s   = 0;
    longint rr  = 0;
    v = 1'b0;
    case (c)
      4'b0000: rr = ua & ub;
      4'b0001: rr = ua | ub;
      4'b0010: begin s = sa + sb; rr = s & m; v = (s > mx) || (s < mn); end
      4'b0110: begin s = sa - sb; rr = s & m; v = (s > mx) || (s < mn); end
      4'b0111: rr = (sa < sb) ? 1 : 0;
      4'b1100: rr = (~(ua | ub)) & m;
      default: rr = 0;
    endcase
    r = rr[31:0];
  endfunction

  task automatic apply(input int w, input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
    logic [31:0] er, ar;
    logic ev, av, az;
    string rq;
    @(posedge clk);
    if (w == 32) begin a32 = a; b32 = b; c32 = c; end
    else begin a4 = a[3:0]; b4 = b[3:0]; c4 = c; end
    @(negedge clk);
    if (w == 32) begin ar = r32; az = z32; av = v32; end
    else begin ar = {28'd0, r4}; az = z4; av = v4; end
    ref_alu(w, a, b, c, er, ev);
    rq = req_of(c);
    checks++;
    if (ar !== er) begin
      errors++;
      $display("FAIL %s w=%0d ctl=%b a=%h b=%h result actual=%h expected=%h", rq, w, c, a, b, ar, er);
    end
    checks++;
    if (az !== (er == 32'd0)) begin
      errors++;
      $display("FAIL R7 w=%0d ctl=%b a=%h b=%h zero actual=%b expected=%b", w, c, a, b, az, (er == 32'd0));
    end
    checks++;
    if (av !== ev) begin
      errors++;
      $display("FAIL %s w=%0d ctl=%b a=%h b=%h overflow actual=%b expected=%b",
               (c == 4'b0010 || c == 4'b0110) ? "R8" : "R9", w, c, a, b, av, ev);
    end
  endtask

  initial begin
    logic [31:0] ext [5];
    int seed;
    ext[0] = 32'h0000_0000; ext[1] = 32'hFFFF_FFFF; ext[2] = 32'h8000_0000;
    ext[3] = 32'h7FFF_FFFF; ext[4] = 32'h0000_0001;
    seed = 17;
    void'($urandom(seed));
    a32 = '0; b32 = '0; c32 = '0; a4 = '0; b4 = '0; c4 = '0;
    // idle state: zero operands under AND give a zero result (R1, R7)
    apply(32, 32'd0, 32'd0, 4'b0000);
    apply(4, 32'd0, 32'd0, 4'b0000);
    // R11: exhaustive sweep at width 4, all codes incl. unlisted (R10)
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(4, 32'(a), 32'(b), 4'(c));
    // directed signed extremes at width 32 (R5, R8)
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(32, ext[i], ext[j], 4'(c));
    // seeded random at width 32
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 1500; k++)
        apply(32, $urandom(), $urandom(), 4'(c));
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule